// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Front End

This block sits between the interrupt request lines of a small 8-bit processor and its instruction sequencer. It watches five request lines, ranked in a fixed order. The highest one cannot be masked. Three maskable lines each have a hard-wired service address. The lowest maskable line has no fixed address: the requesting device supplies a restart opcode instead. The block keeps the global enable flag and the three per-line mask bits.

The sequencer raises a strobe one cycle before each instruction completes. Requests are judged only in that cycle. When a request wins, the block emits a one-cycle taken pulse with a 16-bit service address. The sequencer uses that address to branch.

When the non-vectored line wins, the block first drives an active-low acknowledge for one cycle. At the end of that cycle it reads the restart opcode from the data bus and converts the opcode into a service address.

Top module: `irq_front`

## Requirements
- R1: Priority is fixed, highest first: non-maskable line, line A, line B, line C, non-vectored line. Only the highest qualified request is served in a sample cycle.
- R2: The fixed service addresses are 0x0024 for the non-maskable line, 0x003C for A, 0x0034 for B and 0x002C for C.
- R3: The non-maskable line is served whatever the global enable and mask bits hold.
- R4: A pulse on `enableStb` sets the global enable. A pulse on `disableStb` clears it. If both pulse in the same cycle, disable wins. All four maskable lines need the enable set.
- R5: A `maskStb` pulse loads `maskWord` into the mask bits: bit 2 masks A, bit 1 masks B and bit 0 masks C, where 1 means masked. The non-vectored line has no mask bit.
- R6: Requests are judged only in a cycle with `sampleStb` high. A winner gives `takenPulse` high for exactly the next cycle, with `serviceAddr` valid. A level request that is raised and dropped between sample cycles is never served.
- R7: When the non-vectored line wins, `ackN` is low for exactly the cycle after the sample. `dataBus` is captured at the end of that cycle. In the following cycle `takenPulse` is high and `serviceAddr` equals opcode bits [5:3] times 8. An opcode of the form 11nnn111 therefore maps to 0x0000 through 0x0038. A `sampleStb` that arrives while `ackN` is low is ignored.
- R8: Accepting any request clears the global enable. This also holds when `enableStb` pulses in the sample cycle.
- R9: Line A is captured on its rising edge. It stays pending after the line drops, until it is served.
- R10: The non-maskable line needs a rising edge and must still be high at the sample. Once it is served, a line that stays high is not served again.
- R11: After reset the enable is clear, all mask bits are set, both edge latches are clear, `ackN` is high and `takenPulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiReq | input | 1 | Non-maskable request |
| reqA | input | 1 | Vectored request A, edge captured |
| reqB | input | 1 | Vectored request B, level |
| reqC | input | 1 | Vectored request C, level |
| reqExt | input | 1 | Non-vectored request, level |
| enableStb | input | 1 | Set global enable |
| disableStb | input | 1 | Clear global enable |
| maskStb | input | 1 | Load mask bits |
| maskWord | input | 3 | New mask bits (A,B,C at bits 2,1,0) |
| sampleStb | input | 1 | Instruction ends next cycle; judge requests |
| dataBus | input | 8 | Restart opcode from the device |
| takenPulse | output | 1 | One-cycle request accepted |
| serviceAddr | output | 16 | Service address, valid with takenPulse |
| ackN | output | 1 | Active-low acknowledge for the non-vectored line |

## Verification
The bench raises several request lines together and removes the current winner one step at a time. This separates the full priority chain from a design that only resolves the top pair.

Single-line patterns are tried with the enable off, with the enable on, and with a mask set. These tell the non-maskable bypass apart from the gating of the maskable lines.

Some pulses are raised and dropped between sample cycles, and some lines are held high across two samples. These distinguish edge capture, level sensing and sampling outside the sample cycle. The restart path is fed two different opcodes, which confirms that the opcode field and not a constant drives the address.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 5;
  localparam int NUM_MASK = 3;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int RST_LSB  = 3;
  localparam int RST_W    = 3;

  // Source index also encodes priority: lower index wins.
  localparam int SRC_NMI = 0;
  localparam int SRC_A   = 1;
  localparam int SRC_B   = 2;
  localparam int SRC_C   = 3;
  localparam int SRC_EXT = 4;

  typedef struct packed {
    logic [NUM_SRC-1:0] grant;     // one-hot winner in a sample cycle
    logic               finishAck; // capture restart opcode this cycle
  } ctlStrobes_t;

  function automatic logic [ADDR_W-1:0] fixedVector(input int idx);
    case (idx)
      SRC_NMI: fixedVector = ADDR_W'(16'h0024);
      SRC_A:   fixedVector = ADDR_W'(16'h003C);
      SRC_B:   fixedVector = ADDR_W'(16'h0034);
      SRC_C:   fixedVector = ADDR_W'(16'h002C);
      default: fixedVector = '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nmiReq,
  input  logic                 reqA,
  input  logic                 reqB,
  input  logic                 reqC,
  input  logic                 reqExt,
  input  logic                 enableStb,
  input  logic                 disableStb,
  input  logic                 maskStb,
  input  logic [NUM_MASK-1:0]  maskWord,
  input  logic [DATA_W-1:0]    dataBus,
  input  ctlStrobes_t          ctl,
  output logic [NUM_SRC-1:0]   pendVec,
  output logic                 takenPulse,
  output logic [ADDR_W-1:0]    serviceAddr,
  output logic                 globalEn,
  output logic [NUM_MASK-1:0]  maskBits
);
  logic nmiPrev, aPrev, nmiLatch, aLatch;
  logic [NUM_SRC-1:0] rawLvl;
  logic takeAny;
  logic [ADDR_W-1:0] grantAddr;

  assign takeAny = |ctl.grant;

  // Edge latches: clear on service, else set on rising edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev  <= 1'b0;
      aPrev    <= 1'b0;
      nmiLatch <= 1'b0;
      aLatch   <= 1'b0;
    end else begin
      nmiPrev <= nmiReq;
      aPrev   <= reqA;
      if (ctl.grant[SRC_NMI])      nmiLatch <= 1'b0;
      else if (nmiReq && !nmiPrev) nmiLatch <= 1'b1;
      if (ctl.grant[SRC_A])        aLatch <= 1'b0;
      else if (reqA && !aPrev)     aLatch <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      maskBits <= '1;
    end else begin
      if (takeAny || disableStb) globalEn <= 1'b0;
      else if (enableStb)        globalEn <= 1'b1;
      if (maskStb) maskBits <= maskWord;
    end
  end

  assign rawLvl[SRC_NMI] = nmiLatch & nmiReq;
  assign rawLvl[SRC_A]   = aLatch;
  assign rawLvl[SRC_B]   = reqB;
  assign rawLvl[SRC_C]   = reqC;
  assign rawLvl[SRC_EXT] = reqExt;

  // Qualification per source: vectored maskables use their own mask bit.
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : gQual
      if (i == SRC_NMI) begin : gNmi
        assign pendVec[i] = rawLvl[i];
      end else if (i <= NUM_MASK) begin : gMasked
        assign pendVec[i] = rawLvl[i] & globalEn & ~maskBits[NUM_MASK-i];
      end else begin : gUnmasked
        assign pendVec[i] = rawLvl[i] & globalEn;
      end
    end
  endgenerate

  always_comb begin
    grantAddr = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (ctl.grant[i]) grantAddr = fixedVector(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takenPulse  <= 1'b0;
      serviceAddr <= '0;
    end else begin
      takenPulse <= 1'b0;
      if (ctl.finishAck) begin
        takenPulse  <= 1'b1;
        serviceAddr <= ADDR_W'({dataBus[RST_LSB +: RST_W], {RST_LSB{1'b0}}});
      end else if (takeAny && !ctl.grant[SRC_EXT]) begin
        takenPulse  <= 1'b1;
        serviceAddr <= grantAddr;
      end
    end
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleStb,
  input  logic [NUM_SRC-1:0] pendVec,
  output ctlStrobes_t        ctl,
  output logic               ackN
);
  typedef enum logic {ST_IDLE, ST_ACK} ctlState_t;
  ctlState_t state;
  logic [NUM_SRC-1:0] winner;

  // Fixed priority pick: lowest index set.
  always_comb begin
    winner = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pendVec[i]) winner = NUM_SRC'(1) << i;
  end

  always_comb begin
    ctl.grant     = (state == ST_IDLE && sampleStb) ? winner : '0;
    ctl.finishAck = (state == ST_ACK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ackN  <= 1'b1;
    end else if (state == ST_ACK) begin
      state <= ST_IDLE;
      ackN  <= 1'b1;
    end else if (ctl.grant[SRC_EXT]) begin
      state <= ST_ACK;
      ackN  <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        nmiReq,
  input  logic        reqA,
  input  logic        reqB,
  input  logic        reqC,
  input  logic        reqExt,
  input  logic        enableStb,
  input  logic        disableStb,
  input  logic        maskStb,
  input  logic [2:0]  maskWord,
  input  logic        sampleStb,
  input  logic [7:0]  dataBus,
  output logic        takenPulse,
  output logic [15:0] serviceAddr,
  output logic        ackN
);
  ctlStrobes_t ctl;
  logic [NUM_SRC-1:0]  pendVec;
  logic                globalEn;
  logic [NUM_MASK-1:0] maskBits;

  irq_datapath uDp (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .reqA(reqA), .reqB(reqB),
    .reqC(reqC), .reqExt(reqExt), .enableStb(enableStb),
    .disableStb(disableStb), .maskStb(maskStb), .maskWord(maskWord),
    .dataBus(dataBus), .ctl(ctl), .pendVec(pendVec),
    .takenPulse(takenPulse), .serviceAddr(serviceAddr),
    .globalEn(globalEn), .maskBits(maskBits)
  );

  irq_control uCtl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .pendVec(pendVec),
    .ctl(ctl), .ackN(ackN)
  );
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sampleStb,
  input logic        maskStb,
  input logic [2:0]  maskWord,
  input logic        ackN,
  input logic        takenPulse,
  input logic [15:0] serviceAddr,
  input logic        globalEn,
  input logic [2:0]  maskBits
);
  // R7: acknowledge lasts one cycle and is followed by a taken pulse
  assert_ack_one_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |=> (ackN && takenPulse));

  // R6: a taken pulse only follows a sample cycle or an acknowledge cycle
  assert_taken_after_sample_R6: assert property (@(posedge clk) disable iff (!rstN)
    takenPulse |-> ($past(sampleStb) || !$past(ackN)));

  // R8: the enable is clear while a directly granted request is reported
  assert_enable_cleared_R8: assert property (@(posedge clk) disable iff (!rstN)
    (takenPulse && $past(ackN)) |-> !globalEn);

  // R3: a maskable vectored line is only taken with the enable set
  assert_gate_needs_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (takenPulse && $past(ackN) && serviceAddr != 16'h0024) |-> $past(globalEn));

  // R5: mask bits follow the mask word after a load
  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(maskStb) |-> (maskBits == $past(maskWord)));

  // R2: every service address lies in the low restart region on 4-byte steps
  assert_addr_shape_R2: assert property (@(posedge clk) disable iff (!rstN)
    takenPulse |-> (serviceAddr[15:6] == 10'd0 && serviceAddr[1:0] == 2'd0));
endmodule

bind irq_front irq_front_chk uChk (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .maskStb(maskStb),
  .maskWord(maskWord), .ackN(ackN), .takenPulse(takenPulse),
  .serviceAddr(serviceAddr), .globalEn(globalEn), .maskBits(maskBits)
);

// File: tb/tb_irq_front.sv
module tb_irq_front;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiReq = 0, reqA = 0, reqB = 0, reqC = 0, reqExt = 0;
  logic enableStb = 0, disableStb = 0, maskStb = 0, sampleStb = 0;
  logic [2:0] maskWord = 3'b111;
  logic [7:0] dataBus = 8'h00;
  logic takenPulse, ackN;
  logic [15:0] serviceAddr;

  int checks = 0;
  int errors = 0;
  logic [15:0] expAddr[$];
  string expTag[$];

  always #5 clk = ~clk;

  irq_front dut (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .reqA(reqA), .reqB(reqB),
    .reqC(reqC), .reqExt(reqExt), .enableStb(enableStb),
    .disableStb(disableStb), .maskStb(maskStb), .maskWord(maskWord),
    .sampleStb(sampleStb), .dataBus(dataBus), .takenPulse(takenPulse),
    .serviceAddr(serviceAddr), .ackN(ackN)
  );

  // Monitor: pop expected item on every taken pulse.
  always @(negedge clk) begin
    if (rstN && takenPulse) begin
      checks++;
      if (expAddr.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected take: actual %h expected none", serviceAddr);
      end else begin
        logic [15:0] e;
        string t;
        e = expAddr.pop_front();
        t = expTag.pop_front();
        if (serviceAddr !== e) begin
          errors++;
          $display("FAIL %s service address: actual %h expected %h", t, serviceAddr, e);
        end
      end
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulseEn();   enableStb = 1; tick(); enableStb = 0; endtask
  task automatic pulseDis();  disableStb = 1; tick(); disableStb = 0; endtask
  task automatic loadMask(input logic [2:0] m);
    maskWord = m; maskStb = 1; tick(); maskStb = 0;
  endtask

  // Driver: one sample cycle, queue expectation if any, then drain.
  task automatic sample(input string tag, input bit expect_, input logic [15:0] a);
    if (expect_) begin expAddr.push_back(a); expTag.push_back(tag); end
    sampleStb = 1; tick(); sampleStb = 0;
    tick(3);
    check({tag, " queue drained"}, expAddr.size(), 0);
    expAddr.delete(); expTag.delete();
  endtask

  initial begin
    fork
      begin
        tick(2000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    tick(3); rstN = 1; tick();
    // R11 reset state
    check("R11 ackN after reset", ackN, 1);
    check("R11 takenPulse after reset", takenPulse, 0);
    reqB = 1; sample("R11 enable clear, masks set", 0, 0); reqB = 0;

    // R3 non-maskable served with enable off and masks set
    nmiReq = 1; tick(); sample("R3 nmi bypass", 1, 16'h0024);
    // R10 held high: not served again
    sample("R10 nmi held no retake", 0, 0);
    nmiReq = 0; tick();
    // R10 pulse dropped before sample
    nmiReq = 1; tick(); nmiReq = 0; tick();
    sample("R10 nmi not held", 0, 0);

    // R1 / R2 priority chain
    loadMask(3'b000); pulseEn();
    reqA = 1; reqB = 1; reqC = 1; tick();
    sample("R1 A over B,C", 1, 16'h003C);
    // R8 enable cleared by accept
    sample("R8 no take after accept", 0, 0);
    pulseEn(); sample("R1 B over C (A latch cleared)", 1, 16'h0034);
    reqB = 0; pulseEn(); sample("R2 C vector", 1, 16'h002C);
    reqC = 0; reqA = 0;

    // R7 non-vectored acknowledge path
    reqExt = 1; dataBus = 8'hDF; pulseEn();
    sampleStb = 1; tick(); sampleStb = 1;
    expAddr.push_back(16'h0018); expTag.push_back("R7 restart DF");
    check("R7 ackN low after sample", ackN, 0);
    tick(); sampleStb = 0;
    check("R7 ackN high again", ackN, 1);
    tick(3);
    check("R7 sample during ack ignored", expAddr.size(), 0);
    expAddr.delete(); expTag.delete();
    dataBus = 8'hF7; pulseEn();
    sample("R7 restart F7", 1, 16'h0030);
    tick();

    // R5 mask B: B masked so non-vectored wins (ext has no mask)
    loadMask(3'b010); reqB = 1; dataBus = 8'hC7; pulseEn();
    sample("R5 B masked, ext served", 1, 16'h0000);
    tick();
    reqExt = 0; pulseEn(); sample("R5 B masked alone", 0, 0);
    reqB = 0;

    // R9 A edge captured then dropped before sample
    loadMask(3'b000); pulseEn();
    reqA = 1; tick(); reqA = 0; tick(2);
    sample("R9 A latched pulse", 1, 16'h003C);

    // R6 level pulse between samples not served
    pulseEn(); reqC = 1; tick(2); reqC = 0; tick();
    sample("R6 C pulse between samples", 0, 0);

    // R1 nmi beats A
    reqA = 1; nmiReq = 1; tick();
    sample("R1 nmi over A", 1, 16'h0024);
    pulseEn(); sample("R9 A still pending", 1, 16'h003C);
    reqA = 0; nmiReq = 0;

    // R4 disable wins over simultaneous enable
    reqB = 1; pulseEn();
    enableStb = 1; disableStb = 1; tick(); enableStb = 0; disableStb = 0;
    sample("R4 disable wins", 0, 0);
    pulseEn(); pulseDis(); sample("R4 disable strobe", 0, 0);
    // R8 enable strobe in sample cycle still cleared by accept
    pulseEn(); enableStb = 1;
    expAddr.push_back(16'h0034); expTag.push_back("R8 accept with enable strobe");
    sampleStb = 1; tick(); sampleStb = 0; enableStb = 0;
    tick(3); expAddr.delete(); expTag.delete();
    sample("R8 enable stays clear", 0, 0);
    reqB = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule